// File: doc/BRIEF.md
# Dual-Clock First-Word-Fallthrough FIFO

This block buffers a stream of words between two clock domains whose clocks run freely and may be unrelated or identical. The producer side offers a word together with two write strobes of opposite sense; the word is stored only when both strobes agree and the block reports room through its input-ready flag. The consumer side sees the oldest word already sitting in an output register, flagged by output-ready, without having asked for it. It takes that word by pulling a read strobe and two output-enable controls low together.

Pointers cross between the domains as Gray code through two-flop synchronizers. Each flag is therefore pessimistic: room or data may show up a few cycles after the other side has acted, but the flags never claim room or data that is not there. A half-full flag and one combined near-edge flag (near empty or near full, with the margin set by a parameter) are computed from the write-side count. One reset, asynchronous to both clocks, clears everything and must be held over at least four rising edges of each clock.

Top module: `dcfifo_fwft`

## Requirements
- R1: While reset is high, and at the first edges after it is released, input-ready, output-ready and half-full are 0 and the near-edge flag is 1; once reset is released and synchronized, input-ready rises to 1.
- R2: A word is stored on a rising write-clock edge only if write strobe `wr_en_hi` is 1, strobe `wr_en_lo_n` is 0 and input-ready is 1; any other combination stores nothing.
- R3: A word is taken on a rising read-clock edge only if `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and output-ready is 1; otherwise the output word and output-ready hold.
- R4: A word written into an empty FIFO appears on `dout` with output-ready 1 without any read request.
- R5: Words leave in exactly the order they were accepted, with the two clocks unrelated.
- R6: When DEPTH words are held, input-ready is 0 and further write attempts store nothing.
- R7: After the last held word is taken, output-ready falls to 0 and no read is accepted.
- R8: Half-full is 1 exactly when the held count is at least DEPTH/2+1.
- R9: The near-edge flag is 1 exactly when the held count is at most OFFSET or at least DEPTH-OFFSET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, free running |
| rclk | input | 1 | Read-side clock, free running |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en_hi | input | 1 | Write strobe, active high |
| wr_en_lo_n | input | 1 | Write strobe, active low |
| din | input | WIDTH | Word to store |
| in_rdy | output | 1 | Room for a word (write clock domain) |
| rd_en_n | input | 1 | Read strobe, active low |
| oe_a_n | input | 1 | First output-enable control, active low |
| oe_b_n | input | 1 | Second output-enable control, active low |
| dout | output | WIDTH | Oldest held word (output register) |
| out_rdy | output | 1 | `dout` holds a valid word (read clock domain) |
| half_full | output | 1 | Held count at least DEPTH/2+1 |
| almost_flag | output | 1 | Held count within OFFSET of empty or of full |

## Verification
The bench builds the block with WIDTH 18, DEPTH 64 and OFFSET 8, with a 10 ns write clock and a 14 ns read clock. The shallow depth puts full, both sides of the half-full threshold and both near-edge thresholds within a few hundred cycles, so each flag boundary is visited on its exact count. The unrelated clock periods make the Gray pointers cross at shifting phases, which exercises the late-rising flag behaviour during mixed traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Half-full rule: strictly more than half the depth is held.
  function automatic logic past_half(input int unsigned cnt, input int unsigned depth);
    return cnt > (depth / 2);
  endfunction

  // Near-edge rule: within ofs words of either empty or full.
  function automatic logic near_edge(input int unsigned cnt, input int unsigned depth,
                                     input int unsigned ofs);
    return (cnt <= ofs) || ((cnt + ofs) >= depth);
  endfunction

endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] bin_nxt,
  output logic [PW-1:0] gray
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign bin_nxt = bin + PW'(inc);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nxt;
      gray <= to_gray(bin_nxt);
    end
  end

  // R5: the pointer seen by the other domain changes at most one bit per cycle
  p_gray_step_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gray ^ $past(gray)));

endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int PW     = 10,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  logic [PW-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= gray_in;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  assign bin_out = from_gray(stage[STAGES-1]);

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int W  = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int N = 1 << AW;

  logic [W-1:0] store [N];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // Output register: reloaded every read cycle from the address of the next word
  always_ff @(posedge rclk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
  parameter int DEPTH  = 512,
  parameter int OFFSET = 64,
  parameter int AW     = 9,
  parameter int PW     = 10
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic [PW-1:0] rgray,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          in_rdy,
  output logic          half_full,
  output logic          almost_flag
);

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, cnt_nxt, wcount_q;

  assign wr_fire = en_hi & ~en_lo_n & in_rdy;

  dcf_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst(rst), .inc(wr_fire),
    .bin(wbin), .bin_nxt(wbin_nxt), .gray(wgray)
  );

  dcf_gray_sync #(.PW(PW), .STAGES(2)) u_rsync (
    .clk(wclk), .rst(rst), .gray_in(rgray), .bin_out(rbin_s)
  );

  assign waddr   = wbin[AW-1:0];
  assign cnt_nxt = wbin_nxt - rbin_s;

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      in_rdy      <= 1'b0;
      half_full   <= 1'b0;
      almost_flag <= 1'b1;
      wcount_q    <= '0;
    end else begin
      in_rdy      <= (cnt_nxt != PW'(DEPTH));
      half_full   <= dcf_pkg::past_half(32'(cnt_nxt), DEPTH);
      almost_flag <= dcf_pkg::near_edge(32'(cnt_nxt), DEPTH, OFFSET);
      wcount_q    <= cnt_nxt;
    end
  end

  // R1: flags leave reset at their reset values
  p_reset_flags_r1: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |-> (!in_rdy && !half_full && almost_flag));

  // R2: the write pointer advances exactly on an accepted write
  p_wptr_step_r2: assert property (@(posedge wclk) disable iff (rst)
    wr_fire |=> (wbin == $past(wbin) + PW'(1)));
  p_wptr_hold_r2: assert property (@(posedge wclk) disable iff (rst)
    !wr_fire |=> $stable(wbin));

  // R6: the held count never exceeds the depth, and a full store blocks writes
  p_count_bound_r6: assert property (@(posedge wclk) disable iff (rst)
    wcount_q <= PW'(DEPTH));
  p_full_blocks_r6: assert property (@(posedge wclk) disable iff (rst)
    (wcount_q == PW'(DEPTH)) |-> !in_rdy);

  // R8: half-full only with more than half held
  p_half_r8: assert property (@(posedge wclk) disable iff (rst)
    half_full |-> (wcount_q > PW'(DEPTH / 2)));

  // R9: near-edge flag low only in the middle band
  p_almost_r9: assert property (@(posedge wclk) disable iff (rst)
    !almost_flag |-> ((wcount_q > PW'(OFFSET)) && (wcount_q < PW'(DEPTH - OFFSET))));

endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
  parameter int AW = 9,
  parameter int PW = 10
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          rd_en_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic [PW-1:0] wgray,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          out_rdy
);

  logic [PW-1:0] rbin, rbin_nxt, wbin_s;

  assign rd_fire = ~rd_en_n & ~oe_a_n & ~oe_b_n & out_rdy;

  dcf_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst(rst), .inc(rd_fire),
    .bin(rbin), .bin_nxt(rbin_nxt), .gray(rgray)
  );

  dcf_gray_sync #(.PW(PW), .STAGES(2)) u_wsync (
    .clk(rclk), .rst(rst), .gray_in(wgray), .bin_out(wbin_s)
  );

  // Next word to present; the output register loads from here every cycle
  assign raddr = rbin_nxt[AW-1:0];

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) out_rdy <= 1'b0;
    else     out_rdy <= (rbin_nxt != wbin_s);
  end

  // R1: output-ready leaves reset low
  p_reset_or_r1: assert property (@(posedge rclk) disable iff (rst)
    $fell(rst) |-> !out_rdy);

  // R7: a read is taken only while a written word is known to the read side
  p_take_nonempty_r7: assert property (@(posedge rclk) disable iff (rst)
    rd_fire |-> (rbin != wbin_s));

  // R7: taking the last known word drops output-ready unless more arrived
  p_empty_drop_r7: assert property (@(posedge rclk) disable iff (rst)
    (rd_fire && (rbin_nxt == wbin_s)) |=> (!out_rdy || (wbin_s != $past(wbin_s))));

endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft #(
  parameter int WIDTH  = 18,
  parameter int DEPTH  = 512,
  parameter int OFFSET = 64
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst,
  input  logic             wr_en_hi,
  input  logic             wr_en_lo_n,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             rd_en_n,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy,
  output logic             half_full,
  output logic             almost_flag
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray;

  dcf_wside #(.DEPTH(DEPTH), .OFFSET(OFFSET), .AW(AW), .PW(PW)) u_wside (
    .wclk(wclk), .rst(rst), .en_hi(wr_en_hi), .en_lo_n(wr_en_lo_n),
    .rgray(rgray), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .in_rdy(in_rdy), .half_full(half_full), .almost_flag(almost_flag)
  );

  dcf_rside #(.AW(AW), .PW(PW)) u_rside (
    .rclk(rclk), .rst(rst), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .wgray(wgray), .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray),
    .out_rdy(out_rdy)
  );

  dcf_mem #(.W(WIDTH), .AW(AW)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(din),
    .rclk(rclk), .raddr(raddr), .rdata(dout)
  );

  // R3: without a take, a presented word and its ready flag hold
  p_hold_output_r3: assert property (@(posedge rclk) disable iff (rst)
    (out_rdy && !rd_fire) |=> (out_rdy && $stable(dout)));

endmodule

// File: tb/tb_dcfifo_fwft.sv
module tb_dcfifo_fwft;

  localparam int W  = 18;
  localparam int D  = 64;
  localparam int OF = 8;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic wr_en_hi = 1'b0, wr_en_lo_n = 1'b1;
  logic [W-1:0] din = '0;
  logic rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic in_rdy, out_rdy, half_full, almost_flag;
  logic [W-1:0] dout;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] model[$];

  always #5ns wclk = ~wclk;
  always #7ns rclk = ~rclk;

  dcfifo_fwft #(.WIDTH(W), .DEPTH(D), .OFFSET(OF)) dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n),
    .din(din), .in_rdy(in_rdy), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .dout(dout), .out_rdy(out_rdy), .half_full(half_full), .almost_flag(almost_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic wr_one(input logic [W-1:0] d);
    forever begin
      @(negedge wclk);
      if (in_rdy) break;
    end
    wr_en_hi = 1'b1; wr_en_lo_n = 1'b0; din = d;
    @(negedge wclk);
    wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
    model.push_back(d);
  endtask

  task automatic rd_one(input string req);
    logic [W-1:0] exp;
    forever begin
      @(negedge rclk);
      if (out_rdy) break;
    end
    exp = model.pop_front();
    chk(req, 32'(dout), 32'(exp));
    rd_en_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
  endtask

  task automatic chk_flags(input string req, input int cnt);
    chk({req, " half_full"}, 32'(half_full), 32'(cnt > D / 2));
    chk({req, " almost_flag"}, 32'(almost_flag), 32'((cnt <= OF) || (cnt >= D - OF)));
  endtask

  // R1: reset values while held and after release
  task automatic t_reset();
    rst = 1'b1;
    repeat (6) @(negedge rclk);
    chk("R1 in_rdy in reset", 32'(in_rdy), 32'(0));
    chk("R1 out_rdy in reset", 32'(out_rdy), 32'(0));
    chk("R1 half_full in reset", 32'(half_full), 32'(0));
    chk("R1 almost_flag in reset", 32'(almost_flag), 32'(1));
    @(negedge wclk);
    rst = 1'b0;
    settle();
    chk("R1 in_rdy after reset", 32'(in_rdy), 32'(1));
    chk("R1 out_rdy after reset", 32'(out_rdy), 32'(0));
    chk_flags("R1", 0);
  endtask

  // R4, R3, R7: fallthrough, hold under partial controls, drain to empty
  task automatic t_fwft();
    wr_one(18'h2A5A5);
    settle();
    chk("R4 out_rdy without read", 32'(out_rdy), 32'(1));
    chk("R4 dout fallthrough", 32'(dout), 32'h2A5A5);
    for (int m = 0; m < 3; m++) begin
      @(negedge rclk);
      rd_en_n = (m == 2); oe_a_n = (m == 0); oe_b_n = (m == 1);
      repeat (4) @(negedge rclk);
      chk("R3 out_rdy held", 32'(out_rdy), 32'(1));
      chk("R3 dout held", 32'(dout), 32'h2A5A5);
    end
    rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
    rd_one("R3 take word");
    settle();
    chk("R7 out_rdy after last take", 32'(out_rdy), 32'(0));
  endtask

  // R2: wrong strobe combinations store nothing
  task automatic t_wr_gate();
    @(negedge wclk);
    wr_en_hi = 1'b0; wr_en_lo_n = 1'b0; din = 18'h01111;
    @(negedge wclk);
    wr_en_hi = 1'b1; wr_en_lo_n = 1'b1; din = 18'h02222;
    @(negedge wclk);
    wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
    settle();
    chk("R2 no store on bad strobes", 32'(out_rdy), 32'(0));
    wr_one(18'h03333);
    settle();
    chk("R2 only valid word stored", 32'(dout), 32'h03333);
    rd_one("R2 drain");
    settle();
    chk("R2 empty again", 32'(out_rdy), 32'(0));
  endtask

  // R6, R8, R9, R5: fill to full checking flag edges, then drain in order
  task automatic t_fill();
    for (int k = 1; k <= D; k++) begin
      wr_one(W'(k * 37 + 5));
      if (k == OF || k == OF + 1 || k == D / 2 || k == D / 2 + 1 ||
          k == D - OF - 1 || k == D - OF || k == D) begin
        settle();
        chk_flags($sformatf("R8 R9 count %0d", k), k);
      end
    end
    chk("R6 in_rdy low when full", 32'(in_rdy), 32'(0));
    @(negedge wclk);
    wr_en_hi = 1'b1; wr_en_lo_n = 1'b0; din = 18'h3FFFF;
    repeat (3) @(negedge wclk);
    wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
    for (int k = 0; k < D; k++) rd_one("R5 fill order");
    settle();
    chk("R6 no extra word stored", 32'(out_rdy), 32'(0));
    chk("R6 in_rdy back", 32'(in_rdy), 32'(1));
    chk_flags("R8 R9 drained", 0);
  endtask

  // R5: mixed traffic with random gaps on both sides
  task automatic t_stream();
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          repeat ($urandom % 3) @(negedge wclk);
          wr_one(W'($urandom));
        end
      end
      begin
        for (int i = 0; i < 300; i++) begin
          repeat ($urandom % 4) @(negedge rclk);
          rd_one("R5 stream order");
        end
      end
    join
    settle();
    chk("R5 stream empty", 32'(out_rdy), 32'(0));
    chk("R5 model empty", 32'(model.size()), 32'(0));
  endtask

  initial begin
    t_reset();
    t_fwft();
    t_wr_gate();
    t_fill();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule